// File: doc/BRIEF.md
# Rotating Kernel-Bank Scheduler

This block sequences a group of N processing elements (PEs) that together build an image from a kernel array. The kernel array is split across N memory banks by the low part of the word address. Each PE owns one slice of the image partial sum. Over N stages, each PE must read from every kernel bank exactly once.

The scheduler assigns banks on a diagonal. In stage `t`, PE `p` is served by bank `(p + t) mod N`, so no two PEs ever address the same bank in the same cycle and no arbitration is needed. Within a stage it issues a programmable number of beats. On each beat every PE receives:

- a bank select;
- a local (in-bank) address;
- the matching flat kernel word address.

Beats are offered on a valid/ready pair. While `issue_ready` is low, the current beat is held unchanged; a beat completes only on a cycle with both valid and ready high.

Each PE reports the end of its stage with a `pe_stage_done` flag, which may arrive at any time during the stage. The stage advances once all flags have been seen and all beats are issued. A pulse marks each stage boundary, and a level output marks completion after the last stage.

Top module: `bank_sched`

## Requirements
- R1: After reset, `issue_valid`, `busy`, `done` and `stage_tick` are 0 and `stage` is 0.
- R2: A `start` pulse while idle or done latches `stage_len`. In the following cycle, `issue_valid` and `busy` are 1, `stage` is 0 and every local address is 0.
- R3: In stage `t`, the bank select of PE `p` equals `(p + t) mod N`, and the N bank selects are pairwise distinct in every issuing cycle.
- R4: The local address of every PE equals the index of the current beat within the stage, from 0 to len-1. The word address equals `local*N + bank`, so its residue mod N is the bank and its quotient is the local address.
- R5: While `issue_valid` is 1 and `issue_ready` is 0, `issue_valid`, `stage` and all addresses hold. The beat index advances only on a cycle with both `issue_valid` and `issue_ready` high.
- R6: After the last beat of a stage, `issue_valid` stays 0 until every PE's done bit has been seen high. Done bits are remembered from the start of the stage, so a one-cycle pulse counts.
- R7: A stage advances when its last beat is taken and all done bits have been seen. In the next cycle, `stage_tick` is 1 for that cycle and `stage` has grown by one. If all done bits arrived before the last beat, the new stage issues with no idle cycle.
- R8: Once stage N-1 advances, `done` becomes 1 and `busy` and `issue_valid` become 0. They stay that way until the next `start`, which begins a new run.
- R9: A `stage_len` of 0 is treated as 1. A change of `stage_len` after `start` has no effect on the running job.
- R10: A `start` pulse while busy is ignored: stage and beat index continue undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (pulse) |
| stage_len | input | LEN_W | Beats per stage, latched at start |
| issue_ready | input | 1 | PEs accept the current beat |
| pe_stage_done | input | N | Per-PE end-of-stage flag |
| issue_valid | output | 1 | A beat is offered |
| pe_bank | output | N*BANK_W | Bank select per PE, PE 0 in low bits |
| pe_laddr | output | N*LEN_W | In-bank address per PE |
| pe_word | output | N*WORD_W | Flat kernel word address per PE |
| stage | output | BANK_W | Current stage index |
| stage_tick | output | 1 | One-cycle pulse after a stage advance |
| busy | output | 1 | Job in progress |
| done | output | 1 | All N stages finished |

## Verification
Two events can fall in the same cycle: the handshake of a stage's last beat, and the completion of the PE done set. The bench provokes this by pulsing all done bits during the first beat, so the set is complete by the final beat. It then expects the new stage to issue in the very next cycle, with `stage_tick` high and no gap in `issue_valid`. The opposite ordering delays the done bits one PE at a time after the beats run out. The bench expects `issue_valid` to stay low, with the stage unchanged, until the last bit lands. Back-pressure and a start pulse while busy are both applied in the middle of stages, and each is judged by whether the beat index continues where it was.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import bsched_pkg::*;
#(
  parameter int N     = 4,
  parameter int LEN_W = 8,
  parameter int STG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] stage_len,
  input  logic             issue_ready,
  input  logic [N-1:0]     pe_stage_done,
  output logic             issue_valid,
  output logic [STG_W-1:0] stage_q,
  output logic [LEN_W-1:0] beat_q,
  output logic             stage_tick,
  output logic             busy,
  output logic             done
);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(N - 1);

  phase_t           ph_q;
  logic [LEN_W-1:0] len_q;
  logic [N-1:0]     seen_q;
  logic [N-1:0]     seen_now;
  logic             all_now, last_beat, hs, adv, idle_like;

  assign issue_valid = (ph_q == PH_ISSUE);
  assign busy        = (ph_q == PH_ISSUE) || (ph_q == PH_WAIT);
  assign done        = (ph_q == PH_DONE);
  assign idle_like   = (ph_q == PH_IDLE) || (ph_q == PH_DONE);
  assign seen_now    = seen_q | pe_stage_done;
  assign all_now     = &seen_now;
  assign last_beat   = (beat_q == len_q - LEN_W'(1));
  assign hs          = issue_valid && issue_ready;
  assign adv         = all_now && ((ph_q == PH_WAIT) || (hs && last_beat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      len_q      <= LEN_W'(1);
      seen_q     <= '0;
      stage_q    <= '0;
      beat_q     <= '0;
      stage_tick <= 1'b0;
    end else begin
      stage_tick <= adv;
      if (idle_like) begin
        if (start) begin
          ph_q    <= PH_ISSUE;
          len_q   <= (stage_len == '0) ? LEN_W'(1) : stage_len;
          seen_q  <= '0;
          stage_q <= '0;
          beat_q  <= '0;
        end
      end else begin
        seen_q <= seen_now;
        if (hs) begin
          beat_q <= last_beat ? '0 : beat_q + LEN_W'(1);
        end
        if (adv) begin
          seen_q <= '0;
          if (stage_q == LAST_STG) begin
            ph_q <= PH_DONE;
          end else begin
            stage_q <= stage_q + STG_W'(1);
            ph_q    <= PH_ISSUE;
          end
        end else if (hs && last_beat) begin
          ph_q <= PH_WAIT;
        end
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> (issue_valid && $stable(beat_q) && $stable(stage_q))); // R5
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (beat_q < len_q)); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!issue_valid && !busy)); // R8
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((stage_q == $past(stage_q)) || (stage_q == $past(stage_q) + STG_W'(1)))); // R7
endmodule

// File: rtl/bank_rotor.sv
module bank_rotor #(
  parameter int N      = 4,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0]   stage_q,
  output logic [N*BANK_W-1:0] banks
);
  for (genvar p = 0; p < N; p++) begin : g_pe
    logic [BANK_W:0] sum;
    assign sum = (BANK_W+1)'(p) + {1'b0, stage_q};
    assign banks[p*BANK_W +: BANK_W] =
      (sum >= (BANK_W+1)'(N)) ? BANK_W'(sum - (BANK_W+1)'(N)) : BANK_W'(sum);
  end
endmodule

// File: rtl/addr_pack.sv
module addr_pack #(
  parameter int N      = 4,
  parameter int LEN_W  = 8,
  parameter int BANK_W = 2,
  parameter int WORD_W = 10
) (
  input  logic [LEN_W-1:0]    beat_q,
  input  logic [N*BANK_W-1:0] banks,
  output logic [N*LEN_W-1:0]  laddr,
  output logic [N*WORD_W-1:0] words
);
  localparam bit POW2 = (N == (1 << BANK_W));

  for (genvar p = 0; p < N; p++) begin : g_pe
    logic [BANK_W-1:0] bk;
    assign bk = banks[p*BANK_W +: BANK_W];
    assign laddr[p*LEN_W +: LEN_W] = beat_q;
    if (POW2) begin : g_shift
      assign words[p*WORD_W +: WORD_W] = {beat_q, bk};
    end else begin : g_mul
      assign words[p*WORD_W +: WORD_W] =
        WORD_W'(beat_q) * WORD_W'(N) + WORD_W'(bk);
    end
  end
endmodule

// File: rtl/bank_sched.sv
module bank_sched #(
  parameter int N      = 4,
  parameter int LEN_W  = 8,
  localparam int BANK_W = (N > 1) ? $clog2(N) : 1,
  localparam int WORD_W = LEN_W + BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    stage_len,
  input  logic                issue_ready,
  input  logic [N-1:0]        pe_stage_done,
  output logic                issue_valid,
  output logic [N*BANK_W-1:0] pe_bank,
  output logic [N*LEN_W-1:0]  pe_laddr,
  output logic [N*WORD_W-1:0] pe_word,
  output logic [BANK_W-1:0]   stage,
  output logic                stage_tick,
  output logic                busy,
  output logic                done
);
  logic [LEN_W-1:0] beat_q;

  sched_ctrl #(.N(N), .LEN_W(LEN_W), .STG_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stage_len(stage_len),
    .issue_ready(issue_ready), .pe_stage_done(pe_stage_done),
    .issue_valid(issue_valid), .stage_q(stage), .beat_q(beat_q),
    .stage_tick(stage_tick), .busy(busy), .done(done)
  );

  bank_rotor #(.N(N), .BANK_W(BANK_W)) u_rot (
    .stage_q(stage), .banks(pe_bank)
  );

  addr_pack #(.N(N), .LEN_W(LEN_W), .BANK_W(BANK_W), .WORD_W(WORD_W)) u_addr (
    .beat_q(beat_q), .banks(pe_bank), .laddr(pe_laddr), .words(pe_word)
  );

  logic [N-1:0] used_mask;
  always_comb begin
    used_mask = '0;
    for (int p = 0; p < N; p++) begin
      used_mask = used_mask | (N'(1) << pe_bank[p*BANK_W +: BANK_W]);
    end
  end

  AST_BANKS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($countones(used_mask) == N)); // R3
endmodule

// File: tb/tb_bank_sched.sv
module tb_bank_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int N5 = 5;
  localparam int LW = 8;
  localparam int BW  = 2;
  localparam int BW5 = 3;
  localparam int WW  = LW + BW;
  localparam int WW5 = LW + BW5;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [LW-1:0] stage_len = 0;
  logic ready = 1;
  logic [N-1:0] pe_done = 0;

  logic issue_valid, stage_tick, busy, done;
  logic [N*BW-1:0] pe_bank;
  logic [N*LW-1:0] pe_laddr;
  logic [N*WW-1:0] pe_word;
  logic [BW-1:0] stage;

  logic v5, t5, b5, d5;
  logic [N5*BW5-1:0] bank5;
  logic [N5*LW-1:0] laddr5;
  logic [N5*WW5-1:0] word5;
  logic [BW5-1:0] stage5;

  int total = 0, bad = 0;
  bit seen_d5 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_sched #(.N(N), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stage_len(stage_len),
    .issue_ready(ready), .pe_stage_done(pe_done), .issue_valid(issue_valid),
    .pe_bank(pe_bank), .pe_laddr(pe_laddr), .pe_word(pe_word), .stage(stage),
    .stage_tick(stage_tick), .busy(busy), .done(done)
  );

  bank_sched #(.N(N5), .LEN_W(LW)) dut5 (
    .clk(clk), .rst_n(rst_n), .start(start), .stage_len(stage_len),
    .issue_ready(ready), .pe_stage_done({N5{1'b1}}), .issue_valid(v5),
    .pe_bank(bank5), .pe_laddr(laddr5), .pe_word(word5), .stage(stage5),
    .stage_tick(t5), .busy(b5), .done(d5)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Continuous relation checks on both sizes (R3, R4)
  always @(negedge clk) begin
    if (rst_n && issue_valid) begin
      for (int p = 0; p < N; p++) begin
        int bk, la, wd;
        bk = int'(pe_bank[p*BW +: BW]);
        la = int'(pe_laddr[p*LW +: LW]);
        wd = int'(pe_word[p*WW +: WW]);
        chk(bk == (p + int'(stage)) % N, "R3 bank4", bk, (p + int'(stage)) % N);
        chk(wd % N == bk && wd / N == la, "R4 word4", wd, la * N + bk);
      end
    end
    if (rst_n && v5) begin
      for (int p = 0; p < N5; p++) begin
        int bk, la, wd;
        bk = int'(bank5[p*BW5 +: BW5]);
        la = int'(laddr5[p*LW +: LW]);
        wd = int'(word5[p*WW5 +: WW5]);
        chk(bk == (p + int'(stage5)) % N5, "R3 bank5", bk, (p + int'(stage5)) % N5);
        chk(wd % N5 == bk && wd / N5 == la, "R4 word5", wd, la * N5 + bk);
      end
      for (int a = 0; a < N5; a++)
        for (int b = a + 1; b < N5; b++)
          chk(bank5[a*BW5 +: BW5] != bank5[b*BW5 +: BW5], "R3 unique5",
              int'(bank5[a*BW5 +: BW5]), -1);
    end
    if (d5) seen_d5 = 1;
  end

  // Runs one stage from a negedge where its first beat is offered.
  task automatic run_stage(input int t, input int len, input bit early,
                           input bit stall, input bit poke);
    chk(issue_valid === 1'b1, "R2 valid", issue_valid, 1);
    chk(int'(stage) == t, "R7 stage", stage, t);
    for (int b = 0; b < len; b++) begin
      chk(int'(pe_laddr[LW-1:0]) == b, "R4 beat", pe_laddr[LW-1:0], b);
      if (stall && b == 1) begin
        ready = 0;
        @(negedge clk);
        chk(issue_valid && int'(pe_laddr[LW-1:0]) == b && int'(stage) == t,
            "R5 hold", pe_laddr[LW-1:0], b);
        @(negedge clk);
        chk(issue_valid && int'(pe_laddr[LW-1:0]) == b, "R5 hold2",
            pe_laddr[LW-1:0], b);
        ready = 1;
      end
      if (early && b == 0) pe_done = '1;
      if (poke && b == 1) start = 1;
      @(negedge clk);
      pe_done = '0;
      start = 0;
      if (poke && b == 1 && len > 2)
        chk(int'(pe_laddr[LW-1:0]) == 2 && int'(stage) == t, "R10 start ignored",
            pe_laddr[LW-1:0], 2);
    end
    if (!early) begin
      for (int p = 0; p < N; p++) begin
        chk(!issue_valid && int'(stage) == t, "R6 wait", issue_valid, 0);
        pe_done = N'(1) << p;
        @(negedge clk);
        pe_done = '0;
      end
    end
    chk(stage_tick === 1'b1, "R7 tick", stage_tick, 1);
    if (t == N - 1) begin
      chk(done && !busy && !issue_valid, "R8 done", done, 1);
    end else begin
      chk(int'(stage) == t + 1 && issue_valid, "R7 advance", stage, t + 1);
    end
  endtask

  task automatic kick(input int len_in);
    stage_len = LW'(len_in);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(issue_valid && busy && stage == 0 && pe_laddr[LW-1:0] == 0,
        "R2 start", issue_valid, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!issue_valid && !busy && !done && !stage_tick && stage == 0,
        "R1 reset", issue_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!issue_valid && !busy && !done, "R1 idle", busy, 0);

    // Job 1: len 3, done bits late, stall and busy start in stage 1
    kick(3);
    stage_len = 8'd7; // R9 latched value must stay 3
    for (int t = 0; t < N; t++) run_stage(t, 3, 1'b0, t == 1, t == 1);
    @(negedge clk);
    chk(done && !issue_valid, "R8 stays done", done, 1);

    // Job 2: len 4, done bits early (coincident advance)
    kick(4);
    for (int t = 0; t < N; t++) run_stage(t, 4, 1'b1, t == 2, 1'b0);

    // Job 3: len 0 treated as one beat
    kick(0);
    for (int t = 0; t < N; t++) run_stage(t, 1, t[0], 1'b0, 1'b0);

    repeat (40) @(negedge clk);
    chk(seen_d5, "R8 five-PE done", seen_d5, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule